// File: doc/BRIEF.md
# Pre-adder Multiplier Front End

This block is the operand and product section of an arithmetic slice. It registers a wide A operand, an 18-bit B operand and a 25-bit D operand, then feeds them into a 25-bit pre-adder. The pre-adder can form D + A or D − A, pass either term alone, or produce zero. Its registered result is multiplied by B as a signed value. The 43-bit product is sign-extended to 48 bits so that a following accumulator can take it directly.

A and B each pass through a two-deep register pair. A 5-bit mode word, applied each cycle, chooses which stage of each pair is used. This lets a caller pick a shorter or longer operand path on the fly without adding a separate pipeline. Every register has its own clock enable, and one synchronous active-low reset clears all of them, with priority over the enables.

A build-time parameter removes the multiplier. In that variant the output is the chosen A register, all of its bits, concatenated above the chosen B register.

Top module: `preadd_mult_front`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register clears and `p_out` reads 0 after that edge, whatever the clock enables and inputs are.
- R2: Each register loads only on an edge where its own clock enable is high, and otherwise holds. The A pair and the B pair chain as input → first stage → second stage.
- R3: `mode_in[0]`=1 makes the pre-adder use the first A stage, and 0 selects the second A stage. `mode_in[4]` makes the same choice for the B operand.
- R4: `mode_in[1]`=1 replaces the A term of the pre-adder with zero.
- R5: `mode_in[2]`=1 brings the D register into the pre-adder, and 0 replaces it with zero.
- R6: `mode_in[3]`=1 makes the pre-adder compute D − A, and 0 makes it compute D + A. Only the low 25 bits of A take part, and the sum wraps modulo 2^25.
- R7: In the multiplier variant, `p_out` is the pre-adder result as a signed 25-bit value times the B operand as a signed 18-bit value, sign-extended from 43 to 48 bits.
- R8: With all enables high, a change on `a_in` or `b_in` reaches `p_out` after exactly 5 rising edges in the multiplier variant, and after exactly 4 in the bypass variant.
- R9: In the bypass variant (`BYPASS_MULT`=1), `p_out` is {selected A register (30 bits), selected B register (18 bits)}. The selection follows `mode_in[0]` and `mode_in[4]`, and `mode_in[3:1]` have no effect.
- R10: While `ce_p` is low, `p_out` holds its value even when the operands or the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset for all registers |
| ce_a1 | input | 1 | Enable of the first A stage |
| ce_a2 | input | 1 | Enable of the second A stage |
| ce_b1 | input | 1 | Enable of the first B stage |
| ce_b2 | input | 1 | Enable of the second B stage |
| ce_d | input | 1 | Enable of the D register |
| ce_ad | input | 1 | Enable of the pre-adder result stage (also the B and concatenation stage beside it) |
| ce_m | input | 1 | Enable of the product register |
| ce_p | input | 1 | Enable of the output register |
| mode_in | input | 5 | Per-cycle operand selection and pre-adder control |
| a_in | input | 30 | A operand |
| b_in | input | 18 | B operand, signed |
| d_in | input | 25 | D operand, signed |
| p_out | output | 48 | Registered product or A:B concatenation |

## Verification
A stage-select fault or a lost enable leaves a stale operand in a register. Once the tests load different values into the first and second stages, that stale operand shows as a wrong product three edges after the mode word that selects it. A sign or wrap error in the pre-adder or the multiplier shows up in the corner cases: the most negative D, the most negative A and B, and a sum of the largest positive D plus one. Those cases give products whose upper bits flip. A fault in the pipeline depth shows up on the exact edge where a new operand is expected, because that edge is counted in both variants.

// File: rtl/pamf_pkg.sv
// Shared definitions for the pre-adder multiplier front end.
// Assumes mode words are 5 bits, with the bit meanings fixed below.
package pamf_pkg;
    // Decoded view of the per-cycle mode word; field order matches bit order 4..0.
    typedef struct packed {
        logic b_first;   // bit 4: use first B stage
        logic sub;       // bit 3: pre-adder subtracts A from D
        logic d_en;      // bit 2: D register takes part
        logic a_zero;    // bit 1: A term forced to zero
        logic a_first;   // bit 0: use first A stage
    } mode_t;
endpackage

// File: rtl/pamf_stage_reg.sv
// Generic pipeline register with synchronous active-low reset and clock enable.
// Assumes reset dominates enable.
module pamf_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> q == $past(d));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
endmodule

// File: rtl/pamf_preadd.sv
// Pre-adder: picks an A stage, optionally zeroes A or D, adds or subtracts.
// Assumes both terms are the same width; the result wraps at that width.
module pamf_preadd
    import pamf_pkg::*;
#(
    parameter int W = 25
) (
    input  logic [W-1:0] a1_lo,
    input  logic [W-1:0] a2_lo,
    input  logic [W-1:0] d,
    input  mode_t        mode,
    output logic [W-1:0] sum
);
    logic [W-1:0] a_term;
    logic [W-1:0] d_term;

    // Form each term and combine them per the mode word.
    always_comb begin
        a_term = mode.a_first ? a1_lo : a2_lo;
        if (mode.a_zero) a_term = '0;
        d_term = mode.d_en ? d : '0;
        sum    = mode.sub ? (d_term - a_term) : (d_term + a_term);
    end
endmodule

// File: rtl/pamf_mult.sv
// Signed asymmetric multiplier; full-width product, no rounding.
// Assumes both operands are two's complement.
module pamf_mult #(
    parameter int XW = 25,
    parameter int YW = 18
) (
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    output logic [XW+YW-1:0] prod
);
    localparam int PW = XW + YW;
    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] ys;

    // Sign-extend both operands to product width, then multiply.
    always_comb begin
        xs   = PW'($signed(x));
        ys   = PW'($signed(y));
        prod = xs * ys;
    end
endmodule

// File: rtl/preadd_mult_front.sv
// Pre-adder multiplier front end. Dual A and B input stages chosen per cycle,
// D register, registered pre-adder result, product register and output register.
// Assumes A_W + B_W equals P_W when the bypass variant is built.
module preadd_mult_front
    import pamf_pkg::*;
#(
    parameter int A_W         = 30,
    parameter int B_W         = 18,
    parameter int D_W         = 25,
    parameter int P_W         = 48,
    parameter bit BYPASS_MULT = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_a1,
    input  logic           ce_a2,
    input  logic           ce_b1,
    input  logic           ce_b2,
    input  logic           ce_d,
    input  logic           ce_ad,
    input  logic           ce_m,
    input  logic           ce_p,
    input  logic [4:0]     mode_in,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [D_W-1:0] d_in,
    output logic [P_W-1:0] p_out
);
    localparam int PROD_W = D_W + B_W;
    localparam int EXT_W  = P_W - PROD_W;
    localparam int CAT_W  = A_W + B_W;

    mode_t          mode;
    logic [A_W-1:0] a1_q, a2_q;
    logic [B_W-1:0] b1_q, b2_q, b_pick, bq_q;
    logic [D_W-1:0] d_q, pre_sum, ad_q;
    logic [P_W-1:0] p_next;

    assign mode = mode_t'(mode_in);

    // Input stages: A and B chain through two registers each.
    pamf_stage_reg #(.W(A_W)) u_a1 (.clk(clk), .rst_n(rst_n), .en(ce_a1), .d(a_in), .q(a1_q));
    pamf_stage_reg #(.W(A_W)) u_a2 (.clk(clk), .rst_n(rst_n), .en(ce_a2), .d(a1_q), .q(a2_q));
    pamf_stage_reg #(.W(B_W)) u_b1 (.clk(clk), .rst_n(rst_n), .en(ce_b1), .d(b_in), .q(b1_q));
    pamf_stage_reg #(.W(B_W)) u_b2 (.clk(clk), .rst_n(rst_n), .en(ce_b2), .d(b1_q), .q(b2_q));
    pamf_stage_reg #(.W(D_W)) u_d  (.clk(clk), .rst_n(rst_n), .en(ce_d),  .d(d_in), .q(d_q));

    // Pre-adder on the low A bits and D.
    pamf_preadd #(.W(D_W)) u_pre (
        .a1_lo(a1_q[D_W-1:0]), .a2_lo(a2_q[D_W-1:0]), .d(d_q), .mode(mode), .sum(pre_sum)
    );

    // B stage choice, registered beside the pre-adder result to keep paths aligned.
    always_comb b_pick = mode.b_first ? b1_q : b2_q;

    pamf_stage_reg #(.W(D_W)) u_ad (.clk(clk), .rst_n(rst_n), .en(ce_ad), .d(pre_sum), .q(ad_q));
    pamf_stage_reg #(.W(B_W)) u_bq (.clk(clk), .rst_n(rst_n), .en(ce_ad), .d(b_pick),  .q(bq_q));

    generate
        if (BYPASS_MULT) begin : g_cat
            logic [A_W-1:0]   a_pick;
            logic [CAT_W-1:0] ab_q;
            // Concatenation path: full selected A above selected B.
            always_comb a_pick = mode.a_first ? a1_q : a2_q;
            pamf_stage_reg #(.W(CAT_W)) u_ab (
                .clk(clk), .rst_n(rst_n), .en(ce_ad), .d({a_pick, b_pick}), .q(ab_q)
            );
            assign p_next = P_W'(ab_q);
        end else begin : g_mul
            logic [PROD_W-1:0] prod, m_q;
            pamf_mult #(.XW(D_W), .YW(B_W)) u_mul (.x(ad_q), .y(bq_q), .prod(prod));
            pamf_stage_reg #(.W(PROD_W)) u_m (
                .clk(clk), .rst_n(rst_n), .en(ce_m), .d(prod), .q(m_q)
            );
            // Sign extension to the adder width.
            assign p_next = {{EXT_W{m_q[PROD_W-1]}}, m_q};

            assert_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ce_p |=> ($countones(p_out[P_W-1:PROD_W-1]) == 0 ||
                          $countones(p_out[P_W-1:PROD_W-1]) == EXT_W + 1));
        end
    endgenerate

    pamf_stage_reg #(.W(P_W)) u_p (.clk(clk), .rst_n(rst_n), .en(ce_p), .d(p_next), .q(p_out));

    assert_azero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_ad && mode.a_zero && !mode.d_en) |=> ad_q == '0);
    assert_dpass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_ad && mode.a_zero && mode.d_en && !mode.sub) |=> ad_q == $past(d_q));
endmodule

// File: tb/preadd_mult_front_tb.sv
`timescale 1ns/1ps
module preadd_mult_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p;
    logic [4:0]  mode_in;
    logic [29:0] a_in;
    logic [17:0] b_in;
    logic [24:0] d_in;
    logic [47:0] p_mul, p_cat;
    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    preadd_mult_front #(.BYPASS_MULT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2),
        .ce_d(ce_d), .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p), .mode_in(mode_in),
        .a_in(a_in), .b_in(b_in), .d_in(d_in), .p_out(p_mul));
    preadd_mult_front #(.BYPASS_MULT(1'b1)) u_byp (
        .clk(clk), .rst_n(rst_n), .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2),
        .ce_d(ce_d), .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p), .mode_in(mode_in),
        .a_in(a_in), .b_in(b_in), .d_in(d_in), .p_out(p_cat));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic all_ce(input logic v);
        {ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p} = {8{v}};
    endtask

    // Reference from the requirements: product variant.
    function automatic logic [47:0] ref_mul(input logic [29:0] a1, input logic [29:0] a2,
            input logic [17:0] b1, input logic [17:0] b2, input logic [24:0] d, input logic [4:0] m);
        logic [24:0] at, dt, pre;
        logic [17:0] bs;
        logic signed [47:0] x, y;
        at  = m[0] ? a1[24:0] : a2[24:0];
        if (m[1]) at = '0;
        dt  = m[2] ? d : '0;
        pre = m[3] ? dt - at : dt + at;
        bs  = m[4] ? b1 : b2;
        x = 48'($signed(pre));
        y = 48'($signed(bs));
        return x * y;
    endfunction

    // Reference from the requirements: bypass variant.
    function automatic logic [47:0] ref_cat(input logic [29:0] a1, input logic [29:0] a2,
            input logic [17:0] b1, input logic [17:0] b2, input logic [4:0] m);
        return {m[0] ? a1 : a2, m[4] ? b1 : b2};
    endfunction

    // Load distinct first and second stage values, then freeze the input stages.
    task automatic load(input logic [29:0] a1, input logic [29:0] a2,
            input logic [17:0] b1, input logic [17:0] b2, input logic [24:0] d);
        all_ce(1'b1);
        a_in = a2; b_in = b2;
        tick(2);
        ce_a2 = 1'b0; ce_b2 = 1'b0;
        a_in = a1; b_in = b1; d_in = d;
        tick(1);
        ce_a1 = 1'b0; ce_b1 = 1'b0; ce_d = 1'b0;
        a_in = 30'h155A_A5A5; b_in = 18'h2B3C4; d_in = 25'h0ABCDEF;  // must be ignored (R2)
    endtask

    // Reset clears output regardless of enables.
    task automatic t_reset();
        all_ce(1'b1); mode_in = 5'h1F;
        a_in = 30'h3ABC_DEF1; b_in = 18'h12345; d_in = 25'h1234567;
        rst_n = 1'b0;
        tick(3);
        check("R1 reset product", p_mul, 48'h0);
        check("R1 reset bypass", p_cat, 48'h0);
    endtask

    // Exact latency of each variant.
    task automatic t_latency();
        rst_n = 1'b1; all_ce(1'b1); mode_in = 5'h00;
        a_in = 30'd3; b_in = 18'd5; d_in = '0;
        tick(7);
        check("R8 steady product", p_mul, 48'd15);
        check("R8 steady bypass", p_cat, {30'd3, 18'd5});
        a_in = 30'd7;
        tick(3);
        check("R8 bypass before 4th edge", p_cat, {30'd3, 18'd5});
        tick(1);
        check("R8 bypass at 4th edge", p_cat, {30'd7, 18'd5});
        check("R8 product before 5th edge", p_mul, 48'd15);
        tick(1);
        check("R8 product at 5th edge", p_mul, 48'd35);
    endtask

    // Sweep all 32 mode words against the references.
    task automatic t_modes(input logic [29:0] a1, input logic [29:0] a2,
            input logic [17:0] b1, input logic [17:0] b2, input logic [24:0] d);
        load(a1, a2, b1, b2, d);
        for (int m = 0; m < 32; m++) begin
            mode_in = 5'(m);
            tick(4);
            check("R2/R3/R4/R5/R6/R7 mode sweep", p_mul, ref_mul(a1, a2, b1, b2, d, 5'(m)));
            check("R9 bypass mode sweep", p_cat, ref_cat(a1, a2, b1, b2, 5'(m)));
        end
    endtask

    // Output enable low freezes the output.
    task automatic t_hold_p(input logic [29:0] a1, input logic [29:0] a2,
            input logic [17:0] b1, input logic [17:0] b2, input logic [24:0] d);
        ce_p = 1'b0; mode_in = 5'h00;
        tick(5);
        check("R10 hold product", p_mul, ref_mul(a1, a2, b1, b2, d, 5'h1F));
        check("R10 hold bypass", p_cat, ref_cat(a1, a2, b1, b2, 5'h1F));
        ce_p = 1'b1;
        tick(4);
        check("R10 release product", p_mul, ref_mul(a1, a2, b1, b2, d, 5'h00));
    endtask

    // Reset wins over enables mid-run.
    task automatic t_reset_priority();
        all_ce(1'b1); mode_in = 5'h05;
        rst_n = 1'b0;
        tick(1);
        check("R1 reset over enable product", p_mul, 48'h0);
        check("R1 reset over enable bypass", p_cat, 48'h0);
    endtask

    initial begin
        all_ce(1'b0); mode_in = '0; a_in = '0; b_in = '0; d_in = '0;
        t_reset();
        t_latency();
        t_modes(30'h2ABC_1234, 30'h1000_0005, 18'h20001, 18'h01234, 25'h0FFFFFF);
        t_hold_p(30'h2ABC_1234, 30'h1000_0005, 18'h20001, 18'h01234, 25'h0FFFFFF);
        t_modes(30'h3FFF_FFFF, 30'h0100_0000, 18'h1FFFF, 18'h20000, 25'h1000000);
        t_reset_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule